// File: doc/BRIEF.md
# Two-Port Memory with Mailbox Interrupt Flags

This block is a synchronous two-port memory shared by two processors, called the left and the right side. Each side has its own enable, read/write, output-enable, address, write-data and busy inputs. Each side also has its own read-data, read-valid and interrupt outputs. All inputs are sampled on one common clock. Either side can read or write any word at any time.

The two highest words are mailboxes. The word at the highest address minus one belongs to the left side. The highest word belongs to the right side. When one side writes the other side's mailbox, the owner's interrupt flag goes active. When the owner then touches its mailbox with enable and output-enable asserted, the flag clears. The mailbox bytes are still ordinary storage, so the message rides in the same word that raised the interrupt.

A low level on a side's busy input blocks every flag update that side would cause, both sets and clears. Its memory accesses still happen.

Top module: `mbox_dpram`

## Requirements
- R1: The memory holds 2^ADDR_W words of DATA_W bits (default 2048 x 8). A side writes its data word into the addressed location when its enable and its read/write line are both low at a clock edge.
- R2: A side reads when enable is low, read/write is high and output-enable is low. The addressed word then appears on its read-data output one clock later, with read-valid high for that cycle. In any other cycle, read-valid is low one clock later and read-data keeps its previous value. A side whose enable is high makes no access.
- R3: A right-side write to address 2^ADDR_W-2 (0x7FE) with right busy high sets the left flag. Left irq goes low one clock later.
- R4: The left flag clears when the left side has enable low, output-enable low, address 0x7FE and busy high. The left read/write level does not matter. Left irq returns high one clock later.
- R5: A left-side write to address 2^ADDR_W-1 (0x7FF) with left busy high sets the right flag. A right-side access to 0x7FF with enable low, output-enable low and busy high clears it.
- R6: The mailbox words store and return data like any other location. A flag set or clear does not alter them.
- R7: When the writing side's busy input is low, the set does not happen. When the clearing side's busy input is low, the clear does not happen. In both cases the flag keeps its value.
- R8: If a flag is set and cleared in the same cycle, it ends up set.
- R9: The irq outputs are active low. After reset, both irq outputs are high, both read-valid outputs are low and both read-data outputs are zero. Memory contents are undefined after reset.
- R10: If both sides write the same address in the same cycle, the left side's data is kept. If one side reads an address while the other side writes it, the read returns the word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en_n | input | 1 | Left enable, active low |
| l_wr_n | input | 1 | Left read/write: low writes, high reads |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_busy_n | input | 1 | Left busy; low blocks left-caused flag updates |
| l_rdata | output | DATA_W | Left read data |
| l_rvalid | output | 1 | Left read data valid |
| l_irq_n | output | 1 | Left interrupt flag, active low |
| r_en_n | input | 1 | Right enable, active low |
| r_wr_n | input | 1 | Right read/write: low writes, high reads |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_busy_n | input | 1 | Right busy; low blocks right-caused flag updates |
| r_rdata | output | DATA_W | Right read data |
| r_rvalid | output | 1 | Right read data valid |
| r_irq_n | output | 1 | Right interrupt flag, active low |

## Verification
The bench targets the following corner cases, with the fault each one would expose:
- A set and a clear of one flag in the same cycle. A design with the priority reversed would leave the flag inactive.
- A clear made while the owner is writing its own mailbox. A design that requires read/write high for a clear would keep the flag raised.
- Busy held low on the setting side and on the clearing side. A design without the gating would move the flag.
- Same-address collisions between the two sides. A wrong write order stores the right side's byte. A read-after-write array returns the new byte instead of the old one.

Random traffic is concentrated on a few addresses, including both mailboxes, so these events also occur mixed with ordinary reads and writes.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

   // mailbox owned by a side: left owns top-1, right owns top
   function automatic int unsigned mbox_addr(input int unsigned aw, input int unsigned side);
      return (side == 0) ? ((1 << aw) - 2) : ((1 << aw) - 1);
   endfunction
endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec #(
   parameter int unsigned ADDR_W  = 11,
   parameter int unsigned OWN_MB  = 2046,
   parameter int unsigned PEER_MB = 2047
) (
   input  logic              en_n,
   input  logic              wr_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              busy_n,
   output logic              wr_act,
   output logic              rd_act,
   output logic              set_peer,
   output logic              clr_own
);
   localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_MB);
   localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_MB);

   always_comb begin
      wr_act   = !en_n && !wr_n;
      rd_act   = !en_n && wr_n && !oe_n;
      set_peer = wr_act && (addr == PEER_A) && busy_n;
      clr_own  = !en_n && !oe_n && (addr == OWN_A) && busy_n;
   end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic irq_n
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (set_req)  flag_q <= 1'b1;
      else if (clr_req)  flag_q <= 1'b0;
   end

   assign irq_n = !flag_q;

   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> !irq_n);
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !set_req) |=> irq_n);
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_req && !clr_req) |=> $stable(irq_n));
endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_l,
   input  logic              rd_l,
   input  logic [ADDR_W-1:0] addr_l,
   input  logic [DATA_W-1:0] wd_l,
   input  logic              wr_r,
   input  logic              rd_r,
   input  logic [ADDR_W-1:0] addr_r,
   input  logic [DATA_W-1:0] wd_r,
   output logic [DATA_W-1:0] rd_data_l,
   output logic              rd_vld_l,
   output logic [DATA_W-1:0] rd_data_r,
   output logic              rd_vld_r
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // right first, left last: the later update wins on a collision
   always_ff @(posedge clk) begin
      if (wr_r) mem[addr_r] <= wd_r;
      if (wr_l) mem[addr_l] <= wd_l;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_l <= '0;
         rd_vld_l  <= 1'b0;
         rd_data_r <= '0;
         rd_vld_r  <= 1'b0;
      end else begin
         rd_vld_l <= rd_l;
         rd_vld_r <= rd_r;
         if (rd_l) rd_data_l <= mem[addr_l];
         if (rd_r) rd_data_r <= mem[addr_r];
      end
   end

   p_no_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_l |=> $stable(rd_data_l));
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_en_n,
   input  logic              l_wr_n,
   input  logic              l_oe_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   input  logic              l_busy_n,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_rvalid,
   output logic              l_irq_n,
   input  logic              r_en_n,
   input  logic              r_wr_n,
   input  logic              r_oe_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   input  logic              r_busy_n,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_rvalid,
   output logic              r_irq_n
);
   import mbox_pkg::*;

   localparam int unsigned SIDES = 2;

   initial begin
      assert (ADDR_W >= 2 && ADDR_W <= 16) else $fatal(1, "ADDR_W out of range");
      assert (DATA_W >= 1) else $fatal(1, "DATA_W out of range");
   end

   logic              en_n   [SIDES];
   logic              wr_n   [SIDES];
   logic              oe_n   [SIDES];
   logic              busy_n [SIDES];
   logic [ADDR_W-1:0] addr   [SIDES];
   logic              wr_act [SIDES];
   logic              rd_act [SIDES];
   logic              set_pr [SIDES];
   logic              clr_ow [SIDES];
   logic              irq_n  [SIDES];

   always_comb begin
      en_n[SIDE_L] = l_en_n;   en_n[SIDE_R] = r_en_n;
      wr_n[SIDE_L] = l_wr_n;   wr_n[SIDE_R] = r_wr_n;
      oe_n[SIDE_L] = l_oe_n;   oe_n[SIDE_R] = r_oe_n;
      busy_n[SIDE_L] = l_busy_n; busy_n[SIDE_R] = r_busy_n;
      addr[SIDE_L] = l_addr;   addr[SIDE_R] = r_addr;
   end

   for (genvar g = 0; g < SIDES; g++) begin : g_side
      mbox_port_dec #(
         .ADDR_W (ADDR_W),
         .OWN_MB (mbox_addr(ADDR_W, g)),
         .PEER_MB(mbox_addr(ADDR_W, 1 - g))
      ) i_dec (
         .en_n    (en_n[g]),
         .wr_n    (wr_n[g]),
         .oe_n    (oe_n[g]),
         .addr    (addr[g]),
         .busy_n  (busy_n[g]),
         .wr_act  (wr_act[g]),
         .rd_act  (rd_act[g]),
         .set_peer(set_pr[g]),
         .clr_own (clr_ow[g])
      );

      mbox_flag i_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_req(set_pr[1-g]),
         .clr_req(clr_ow[g]),
         .irq_n  (irq_n[g])
      );
   end

   mbox_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_l     (wr_act[SIDE_L]),
      .rd_l     (rd_act[SIDE_L]),
      .addr_l   (l_addr),
      .wd_l     (l_wdata),
      .wr_r     (wr_act[SIDE_R]),
      .rd_r     (rd_act[SIDE_R]),
      .addr_r   (r_addr),
      .wd_r     (r_wdata),
      .rd_data_l(l_rdata),
      .rd_vld_l (l_rvalid),
      .rd_data_r(r_rdata),
      .rd_vld_r (r_rvalid)
   );

   assign l_irq_n = irq_n[SIDE_L];
   assign r_irq_n = irq_n[SIDE_R];

   p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_en_n && l_wr_n && !l_oe_n) |=> l_rvalid);
   p_idle_no_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      r_en_n |=> !r_rvalid);
   p_left_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_en_n && !r_wr_n && r_busy_n && r_addr == ADDR_W'((1 << ADDR_W) - 2)) |=> !l_irq_n);
   p_right_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_en_n && !l_wr_n && l_busy_n && l_addr == ADDR_W'((1 << ADDR_W) - 1)) |=> !r_irq_n);
endmodule

// File: tb/test_mbox_dpram.sv
module test_mbox_dpram;
   localparam int AW = 11;
   localparam int DW = 8;
   localparam int CLK_PERIOD = 10;
   localparam logic [AW-1:0] MB_L = 11'h7FE;
   localparam logic [AW-1:0] MB_R = 11'h7FF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_en_n = 1, l_wr_n = 1, l_oe_n = 1, l_busy_n = 1;
   logic r_en_n = 1, r_wr_n = 1, r_oe_n = 1, r_busy_n = 1;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_wdata = '0, r_wdata = '0;
   logic [DW-1:0] l_rdata, r_rdata;
   logic l_rvalid, r_rvalid, l_irq_n, r_irq_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) i_mbox_dpram (.*);

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   logic [DW-1:0] m_mem   [1 << AW];
   bit            m_known [1 << AW];
   bit m_lf = 0, m_rf = 0;
   logic [DW-1:0] e_lrd = '0, e_rrd = '0;
   bit e_lrv = 0, e_rrv = 0, k_lrd = 1, k_rrd = 1;

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit flag_next(input bit cur, input bit set, input bit clr);
      return set ? 1'b1 : (clr ? 1'b0 : cur);   // R8: set wins
   endfunction

   task automatic compare_all(input string ctx);
      chk({ctx, " R2 l_rvalid"}, DW'(l_rvalid), DW'(e_lrv));
      chk({ctx, " R2 r_rvalid"}, DW'(r_rvalid), DW'(e_rrv));
      if (k_lrd) chk({ctx, " R2 l_rdata"}, l_rdata, e_lrd);
      if (k_rrd) chk({ctx, " R2 r_rdata"}, r_rdata, e_rrd);
      chk({ctx, " R3/R4 l_irq_n"}, DW'(l_irq_n), DW'(!m_lf));
      chk({ctx, " R5 r_irq_n"}, DW'(r_irq_n), DW'(!m_rf));
   endtask

   // drive one cycle at a negedge, model it, compare after the edge
   task automatic cyc(input string ctx,
                      input logic le, lw, lo, input logic [AW-1:0] la, input logic [DW-1:0] ld, input logic lb,
                      input logic re, rw, ro, input logic [AW-1:0] ra, input logic [DW-1:0] rd, input logic rb);
      bit lwr, rwr, lrd, rrd;
      l_en_n = le; l_wr_n = lw; l_oe_n = lo; l_addr = la; l_wdata = ld; l_busy_n = lb;
      r_en_n = re; r_wr_n = rw; r_oe_n = ro; r_addr = ra; r_wdata = rd; r_busy_n = rb;
      lwr = !le && !lw;  rwr = !re && !rw;
      lrd = !le && lw && !lo; rrd = !re && rw && !ro;
      e_lrv = lrd; e_rrv = rrd;
      if (lrd) begin e_lrd = m_mem[la]; k_lrd = m_known[la]; end   // R10 old data
      if (rrd) begin e_rrd = m_mem[ra]; k_rrd = m_known[ra]; end
      m_lf = flag_next(m_lf, rwr && ra == MB_L && rb, !le && !lo && la == MB_L && lb);
      m_rf = flag_next(m_rf, lwr && la == MB_R && lb, !re && !ro && ra == MB_R && rb);
      if (rwr) begin m_mem[ra] = rd; m_known[ra] = 1; end
      if (lwr) begin m_mem[la] = ld; m_known[la] = 1; end           // R10 left wins
      @(posedge clk);
      @(negedge clk);
      compare_all(ctx);
   endtask

   localparam logic [AW-1:0] ANY = '0;

   initial begin
      int wd = 0;
      while (!done && wd < 200000) begin @(posedge clk); wd++; end
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual expired expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 l_irq_n reset", DW'(l_irq_n), 8'd1);
      chk("R9 r_irq_n reset", DW'(r_irq_n), 8'd1);
      chk("R9 l_rvalid reset", DW'(l_rvalid), 8'd0);
      chk("R9 r_rdata reset", r_rdata, 8'd0);

      // R1/R2 plain write then read both sides
      cyc("R1 wr", 0,0,1, 11'h005, 8'hA5, 1,   0,0,1, 11'h006, 8'h5A, 1);
      cyc("R2 rd", 0,1,0, 11'h006, 8'h00, 1,   0,1,0, 11'h005, 8'h00, 1);
      chk("R2 l_rdata cross", l_rdata, 8'h5A);
      // R2: oe high gives no read
      cyc("R2 oe", 0,1,1, 11'h005, 8'h00, 1,   1,1,0, 11'h006, 8'h00, 1);
      chk("R2 no valid oe high", DW'(l_rvalid), 8'd0);

      // R3 right writes left mailbox, R6 data is stored
      cyc("R3 set", 1,1,1, ANY, 8'h00, 1,   0,0,1, MB_L, 8'h3C, 1);
      chk("R3 l_irq_n low", DW'(l_irq_n), 8'd0);
      // R7 clear blocked by left busy
      cyc("R7 clr blk", 0,1,0, MB_L, 8'h00, 0,   1,1,1, ANY, 8'h00, 1);
      chk("R7 l_irq_n stays low", DW'(l_irq_n), 8'd0);
      chk("R6 mailbox data", l_rdata, 8'h3C);
      // R4 clear while writing own mailbox (read/write is don't care)
      cyc("R4 clr wr", 0,0,0, MB_L, 8'h77, 1,   1,1,1, ANY, 8'h00, 1);
      chk("R4 l_irq_n high", DW'(l_irq_n), 8'd1);
      // R7 set blocked by right busy
      cyc("R7 set blk", 1,1,1, ANY, 8'h00, 1,   0,0,1, MB_L, 8'h11, 0);
      chk("R7 l_irq_n stays high", DW'(l_irq_n), 8'd1);
      // R5 left sets right flag, right clears
      cyc("R5 set", 0,0,1, MB_R, 8'h99, 1,   1,1,1, ANY, 8'h00, 1);
      chk("R5 r_irq_n low", DW'(r_irq_n), 8'd0);
      // R8 set and clear together
      cyc("R8 both", 0,0,1, MB_R, 8'h98, 1,   0,1,0, MB_R, 8'h00, 1);
      chk("R8 r_irq_n stays low", DW'(r_irq_n), 8'd0);
      cyc("R5 clr", 1,1,1, ANY, 8'h00, 1,   0,1,0, MB_R, 8'h00, 1);
      chk("R5 r_irq_n high", DW'(r_irq_n), 8'd1);
      chk("R6 mailbox readback", r_rdata, 8'h98);
      // R10 collision and read-before-write
      cyc("R10 coll", 0,0,1, 11'h010, 8'hC1, 1,   0,0,1, 11'h010, 8'hD2, 1);
      cyc("R10 rbw", 0,1,0, 11'h010, 8'h00, 1,   0,0,1, 11'h010, 8'hE3, 1);
      chk("R10 left wins / old data", l_rdata, 8'hC1);

      // constrained random traffic on a small address set
      for (int i = 0; i < 4000; i++) begin
         logic [AW-1:0] la, ra;
         int sa = $urandom_range(0, 9), sb = $urandom_range(0, 9);
         la = (sa >= 8) ? ((sa == 8) ? MB_L : MB_R) : AW'(sa);
         ra = (sb >= 8) ? ((sb == 8) ? MB_L : MB_R) : AW'(sb);
         cyc("rand",
             ($urandom_range(0, 4) == 0), $urandom_range(0, 1), $urandom_range(0, 1), la,
             DW'($urandom), ($urandom_range(0, 5) != 0),
             ($urandom_range(0, 4) == 0), $urandom_range(0, 1), $urandom_range(0, 1), ra,
             DW'($urandom), ($urandom_range(0, 5) != 0));
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule